// File: doc/BRIEF.md
# Non-Volatile Bank Controller with Background Row Commit

This block controls one bank of a non-volatile memory that sits behind a DDR4-style command interface. An activate command pulls a whole row out of the non-volatile array into a latching sense register. Reads and writes then work only on that register. Each write also updates a shadow copy of the row. The shadow copy is written back to the array in the background, so a write becomes persistent within a bounded window. The bank needs no refresh, and a read's data latency does not depend on any commit in flight.

Commands arrive already decoded, one per clock at most: a valid strobe, an opcode, a row, a column and a 64-bit write word. The controller returns read data after a fixed number of cycles. It also exposes the strobes it uses to load a row from the array and to store a row back. Nanosecond timings become clock cycles through a clock-period parameter given in picoseconds. Read latency is rounded up. The persistence window is rounded down, so the deadline is never exceeded.

The controller has four states:
- ST_IDLE: no row is open.
- ST_OPEN: a row is open and clean.
- ST_COMMIT: a row is open and its shadow is waiting to be stored.
- ST_DRAIN: a precharge has been accepted and is held off until the pending store completes.

The transitions are:
- ST_IDLE to ST_OPEN on an activate.
- ST_OPEN to ST_COMMIT on a write.
- ST_OPEN to ST_IDLE on a precharge.
- ST_COMMIT to ST_COMMIT on a write.
- ST_COMMIT to ST_OPEN when the store fires.
- ST_COMMIT to ST_DRAIN on a precharge while the store is still pending.
- ST_COMMIT to ST_IDLE on a precharge in the same cycle as the store.
- ST_DRAIN to ST_IDLE when the store fires.

Top module: `nvb_bank_ctrl`

## Requirements
- R1: After reset, rd_valid, busy, arr_store and arr_load are all 0 and no row is open.
- R2: The opcode encoding on cmd_op is 0 = activate, 1 = read, 2 = write, 3 = precharge. An activate in ST_IDLE raises arr_load in the same cycle and opens the addressed row. An activate while a row is open, or while draining, is ignored and arr_load stays 0.
- R3: A read accepted at a clock edge drives rd_valid high, for one cycle, with the addressed word on rd_data, exactly AA_CYC edges after the issue edge (the issue edge counts as the first). AA_CYC = ceil(13500 ps / CLK_PS), which is 18 at the defaults. The latency is the same while a commit is pending.
- R4: A write replaces the addressed word of the open row. A later read of that word returns the new data, including while the row's commit is still pending.
- R5: A write into a clean row starts a commit. arr_store pulses exactly once, in the cycle after PERSIST_CYC - 1 further edges, where PERSIST_CYC = floor(46250 ps / CLK_PS), which is 61 at the defaults. The array is updated at the end of that cycle, so reopening the row later returns the written data.
- R6: A write while a commit is pending joins that commit without moving its deadline. A write accepted in the very cycle arr_store is high starts a fresh full window.
- R7: A precharge with no commit pending closes the row at once, and busy stays 0.
- R8: A precharge while a commit is pending raises busy from the next cycle until the store completes, and then the bank closes. While busy is high, every command is ignored.
- R9: A read, write or precharge with no row open is ignored: no rd_valid and no arr_store result from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 2 | Opcode: 0 activate, 1 read, 2 write, 3 precharge |
| cmd_row | input | ROW_W | Row address for activate |
| cmd_col | input | COL_W | Column (word) address for read and write |
| cmd_wdata | input | DATA_W | Write word |
| rd_valid | output | 1 | Read data valid, one cycle per accepted read |
| rd_data | output | DATA_W | Read word |
| arr_load | output | 1 | Row is being loaded from the array this cycle |
| arr_store | output | 1 | Shadow row is being stored to the array this cycle |
| busy | output | 1 | Precharge is held off until the pending store finishes |

## Verification
On every cycle, the assertions check the following:
- an activate always leads into ST_OPEN;
- a write always leaves a pending commit;
- a clean precharge closes the bank without busy;
- busy only drops after a store;
- a pending commit never grows older than the persistence window.

Only the bench scenarios can show the data-related behaviour. That covers read data arriving on exactly the latency edge, and written words surviving a close and reopen through the array. It also covers the joined commit and the restarted commit after a write in the store cycle, and the exact length of the busy hold.

// File: rtl/nvb_pkg.sv
package nvb_pkg;

    typedef enum logic [1:0] {
        OP_ACT = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2,
        OP_PRE = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_OPEN,
        ST_COMMIT,
        ST_DRAIN
    } state_e;

    // Latency conversion: round up, never below one cycle.
    function automatic int cyc_ceil(input int ps, input int per_ps);
        int c;
        c = (ps + per_ps - 1) / per_ps;
        return (c < 1) ? 1 : c;
    endfunction

    // Deadline conversion: round down so the window is never exceeded.
    function automatic int cyc_floor(input int ps, input int per_ps);
        int c;
        c = ps / per_ps;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/nvb_array.sv
module nvb_array #(
    parameter int ROW_W  = 4,
    parameter int ROW_BW = 512
) (
    input  logic              clk,
    input  logic [ROW_W-1:0]  rd_row,
    output logic [ROW_BW-1:0] rd_line,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [ROW_BW-1:0] wr_line
);
    localparam int ROWS = 1 << ROW_W;

    logic [ROW_BW-1:0] cells [ROWS];

    assign rd_line = cells[rd_row];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_row] <= wr_line;
        end
    end
endmodule

// File: rtl/nvb_sense.sv
module nvb_sense #(
    parameter int COL_W  = 3,
    parameter int DATA_W = 64
) (
    input  logic                         clk,
    input  logic                         load_en,
    input  logic [(1<<COL_W)*DATA_W-1:0] load_line,
    input  logic                         wr_en,
    input  logic [COL_W-1:0]             wr_col,
    input  logic [DATA_W-1:0]            wr_word,
    input  logic [COL_W-1:0]             rd_col,
    output logic [DATA_W-1:0]            rd_word,
    output logic [(1<<COL_W)*DATA_W-1:0] shadow_line
);
    localparam int COLS = 1 << COL_W;

    logic [DATA_W-1:0] latch_q  [COLS];
    logic [DATA_W-1:0] shadow_q [COLS];

    assign rd_word = latch_q[rd_col];

    for (genvar c = 0; c < COLS; c++) begin : g_col
        always_ff @(posedge clk) begin
            if (load_en) begin
                latch_q[c]  <= load_line[c*DATA_W +: DATA_W];
                shadow_q[c] <= load_line[c*DATA_W +: DATA_W];
            end else if (wr_en && wr_col == COL_W'(c)) begin
                latch_q[c]  <= wr_word;
                shadow_q[c] <= wr_word;
            end
        end
        assign shadow_line[c*DATA_W +: DATA_W] = shadow_q[c];
    end
endmodule

// File: rtl/nvb_rd_pipe.sv
module nvb_rd_pipe #(
    parameter int DEPTH  = 18,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    logic              v_q [DEPTH];
    logic [DATA_W-1:0] d_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q[0] <= 1'b0;
        end else begin
            v_q[0] <= in_valid;
        end
        d_q[0] <= in_data;
    end

    for (genvar s = 1; s < DEPTH; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q[s] <= 1'b0;
            end else begin
                v_q[s] <= v_q[s-1];
            end
            d_q[s] <= d_q[s-1];
        end
    end

    assign out_valid = v_q[DEPTH-1];
    assign out_data  = d_q[DEPTH-1];
endmodule

// File: rtl/nvb_bank_ctrl.sv
module nvb_bank_ctrl
    import nvb_pkg::*;
#(
    parameter int ROW_W       = 4,
    parameter int COL_W       = 3,
    parameter int DATA_W      = 64,
    parameter int CLK_PS      = 750,
    parameter int TAA_PS      = 13500,
    parameter int TPERSIST_PS = 46250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ROW_W-1:0]  cmd_row,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              arr_load,
    output logic              arr_store,
    output logic              busy
);
    localparam int COLS        = 1 << COL_W;
    localparam int ROW_BW      = COLS * DATA_W;
    localparam int AA_CYC      = cyc_ceil(TAA_PS, CLK_PS);
    localparam int PERSIST_CYC = cyc_floor(TPERSIST_PS, CLK_PS);
    localparam int TMR_W       = $clog2(PERSIST_CYC + 1);

    state_e            state_q, state_d;
    logic [ROW_W-1:0]  open_row_q;
    logic [TMR_W-1:0]  tmr_q;
    logic              row_live, pending;
    logic              acc_act, acc_rd, acc_wr, acc_pre, store_now;
    op_e               op;
    logic [ROW_BW-1:0] arr_line, shadow_line;
    logic [DATA_W-1:0] sense_word;

    assign op        = op_e'(cmd_op);
    assign row_live  = (state_q == ST_OPEN) || (state_q == ST_COMMIT);
    assign pending   = (state_q == ST_COMMIT) || (state_q == ST_DRAIN);
    assign store_now = pending && (tmr_q == '0);
    assign acc_act   = cmd_valid && (op == OP_ACT) && (state_q == ST_IDLE);
    assign acc_rd    = cmd_valid && (op == OP_RD)  && row_live;
    assign acc_wr    = cmd_valid && (op == OP_WR)  && row_live;
    assign acc_pre   = cmd_valid && (op == OP_PRE) && row_live;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (acc_act) state_d = ST_OPEN;
            ST_OPEN: begin
                if (acc_wr)       state_d = ST_COMMIT;
                else if (acc_pre) state_d = ST_IDLE;
            end
            ST_COMMIT: begin
                if (acc_wr)         state_d = ST_COMMIT;
                else if (acc_pre)   state_d = store_now ? ST_IDLE : ST_DRAIN;
                else if (store_now) state_d = ST_OPEN;
            end
            ST_DRAIN:  if (store_now) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register, open row and commit timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            open_row_q <= '0;
            tmr_q      <= '0;
        end else begin
            state_q <= state_d;
            if (acc_act) open_row_q <= cmd_row;
            if (acc_wr && (!pending || store_now)) begin
                tmr_q <= TMR_W'(PERSIST_CYC - 1);
            end else if (pending && tmr_q != '0) begin
                tmr_q <= tmr_q - 1'b1;
            end
        end
    end

    // Output logic.
    always_comb begin
        arr_load  = acc_act;
        arr_store = store_now;
        busy      = (state_q == ST_DRAIN);
    end

    nvb_array #(.ROW_W(ROW_W), .ROW_BW(ROW_BW)) u_array (
        .clk     (clk),
        .rd_row  (cmd_row),
        .rd_line (arr_line),
        .wr_en   (store_now),
        .wr_row  (open_row_q),
        .wr_line (shadow_line)
    );

    nvb_sense #(.COL_W(COL_W), .DATA_W(DATA_W)) u_sense (
        .clk         (clk),
        .load_en     (acc_act),
        .load_line   (arr_line),
        .wr_en       (acc_wr),
        .wr_col      (cmd_col),
        .wr_word     (cmd_wdata),
        .rd_col      (cmd_col),
        .rd_word     (sense_word),
        .shadow_line (shadow_line)
    );

    nvb_rd_pipe #(.DEPTH(AA_CYC), .DATA_W(DATA_W)) u_rd_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (acc_rd),
        .in_data   (sense_word),
        .out_valid (rd_valid),
        .out_data  (rd_data)
    );

    // Age of the oldest uncommitted write, kept independently of the timer.
    logic [TMR_W:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (acc_wr && (!pending || store_now)) begin
            age_q <= '0;
        end else if (pending) begin
            age_q <= age_q + 1'b1;
        end
    end

    // R5
    persist_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> (age_q < (TMR_W+1)'(PERSIST_CYC)));

    // R2
    act_opens_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_load |=> (state_q == ST_OPEN));

    // R4
    write_pends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |=> pending);

    // R7
    clean_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_pre && !pending) |=> (state_q == ST_IDLE && !busy));

    // R8
    busy_ends_on_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(arr_store));
endmodule

// File: tb/nvb_bank_ctrl_tb.sv
module nvb_bank_ctrl_tb;
    localparam int AA      = 18;  // ceil(13500/750)
    localparam int PERSIST = 61;  // floor(46250/750)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [3:0]  cmd_row = '0;
    logic [2:0]  cmd_col = '0;
    logic [63:0] cmd_wdata = '0;
    logic        rd_valid, arr_load, arr_store, busy;
    logic [63:0] rd_data;

    int errors = 0, checks = 0;
    int store_cnt = 0, rdv_cnt = 0, busy_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    nvb_bank_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_wdata(cmd_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .arr_load(arr_load),
        .arr_store(arr_store), .busy(busy)
    );

    always @(negedge clk) begin
        if (arr_store) store_cnt++;
        if (rd_valid)  rdv_cnt++;
        if (busy)      busy_cnt++;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present one command, let one edge sample it; returns 1 ns after the edge.
    task automatic send(input logic [1:0] op, input logic [3:0] row,
                        input logic [2:0] col, input logic [63:0] d);
        cmd_valid = 1'b1; cmd_op = op; cmd_row = row; cmd_col = col; cmd_wdata = d;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    task automatic act(input logic [3:0] row, input bit exp_load, input string req);
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_row = row;
        #1 chk(arr_load == exp_load, req, arr_load, exp_load);
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    task automatic rd_check(input logic [2:0] col, input logic [63:0] exp, input string req);
        send(2'd1, '0, col, '0);
        repeat (AA - 2) @(posedge clk);
        #1 chk(rd_valid == 1'b0, {req, " early"}, rd_valid, 0);
        @(posedge clk); #1;
        chk(rd_valid == 1'b1, {req, " valid"}, rd_valid, 1);
        chk(rd_data == exp, {req, " data"}, rd_data, exp);
    endtask

    task automatic wait_store(output int n);
        n = 0;
        do begin
            @(negedge clk); n++;
        end while (!arr_store && n < 300);
    endtask

    task automatic t_reset();
        chk(!rd_valid && !busy && !arr_store && !arr_load, "R1",
            {rd_valid, busy, arr_store, arr_load}, 0);
    endtask

    task automatic t_idle_ignored();
        int s0 = store_cnt, r0 = rdv_cnt;
        send(2'd1, 0, 3, '0);
        send(2'd2, 0, 3, 64'h1111);
        send(2'd3, 0, 0, '0);
        repeat (AA + 4) @(posedge clk);
        #1;
        chk(rdv_cnt == r0, "R9 rd_valid", rdv_cnt - r0, 0);
        chk(store_cnt == s0, "R9 arr_store", store_cnt - s0, 0);
    endtask

    task automatic t_write_persist();
        int n, s0;
        act(4'd2, 1'b1, "R2 load");
        act(4'd2, 1'b0, "R2 ignored while open");
        s0 = store_cnt;
        send(2'd2, 0, 3'd1, 64'hA5A5_0000_1234_0001);
        // R3 and R4: read during pending commit
        rd_check(3'd1, 64'hA5A5_0000_1234_0001, "R4/R3 pending");
        wait_store(n);
        chk(n == PERSIST - AA, "R5 store timing", n, PERSIST - AA);
        @(posedge clk); #1;
        chk(store_cnt - s0 == 1, "R5 single store", store_cnt - s0, 1);
        send(2'd3, 0, 0, '0);
        chk(busy == 1'b0, "R7 busy", busy, 0);
        act(4'd2, 1'b1, "R7 closed");
        rd_check(3'd1, 64'hA5A5_0000_1234_0001, "R5 persisted");
        send(2'd3, 0, 0, '0);
    endtask

    task automatic t_joined_and_restart();
        int n;
        act(4'd3, 1'b1, "R2 load row3");
        send(2'd2, 0, 3'd0, 64'hB0B0_B0B0_0000_0001);
        repeat (9) @(posedge clk);
        @(negedge clk);
        send(2'd2, 0, 3'd2, 64'hC0C0_C0C0_0000_0002);
        wait_store(n);
        chk(n == PERSIST - 10, "R6 joined deadline", n, PERSIST - 10);
        send(2'd2, 0, 3'd5, 64'hD0D0_0000_0000_0005);
        wait_store(n);
        chk(n == PERSIST, "R6 restart window", n, PERSIST);
        @(posedge clk); #1;
        send(2'd3, 0, 0, '0);
        act(4'd3, 1'b1, "R2 reopen row3");
        rd_check(3'd0, 64'hB0B0_B0B0_0000_0001, "R6 word0");
        rd_check(3'd2, 64'hC0C0_C0C0_0000_0002, "R6 word2");
        rd_check(3'd5, 64'hD0D0_0000_0000_0005, "R6 word5");
        send(2'd3, 0, 0, '0);
    endtask

    task automatic t_drain();
        int b0, s0, r0;
        act(4'd5, 1'b1, "R2 load row5");
        b0 = busy_cnt; s0 = store_cnt; r0 = rdv_cnt;
        send(2'd2, 0, 3'd4, 64'hDEAD_BEEF_0000_0004);
        send(2'd3, 0, 0, '0);
        chk(busy == 1'b1, "R8 busy raised", busy, 1);
        act(4'd6, 1'b0, "R8 act ignored");
        send(2'd1, 0, 3'd4, '0);
        send(2'd2, 0, 3'd4, 64'h0);
        while (busy) @(posedge clk);
        #1;
        repeat (AA + 2) @(posedge clk);
        #1;
        chk(busy_cnt - b0 == PERSIST - 1, "R8 busy length", busy_cnt - b0, PERSIST - 1);
        chk(store_cnt - s0 == 1, "R8 store", store_cnt - s0, 1);
        chk(rdv_cnt == r0, "R8 read ignored", rdv_cnt - r0, 0);
        act(4'd5, 1'b1, "R8 closed");
        rd_check(3'd4, 64'hDEAD_BEEF_0000_0004, "R8 persisted");
        send(2'd3, 0, 0, '0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_ignored();
        t_write_persist();
        t_joined_and_restart();
        t_drain();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule